// File: doc/BRIEF.md
# Multiplexed Asynchronous Memory Access Sequencer

This block runs one read or one write at a time on an external asynchronous memory that shares a single bus for address and data, as NOR flash and pseudo-static RAM parts do. A request port supplies the address, the write data and the direction. Request-side handshaking is a ready/valid pair. The sequencer walks through four programmable phases. First the address is put on the shared bus and the address-valid strobe is pulsed, and then the address is held. After that comes the data strobe window, followed by data hold. Chip select is then kept high for a programmable turnaround gap before the next access can begin.

A memory-side WAIT input can stretch the data strobe window. It has an enable and a polarity select. WAIT goes through a two-stage synchronizer and is acted on only in the data strobe window. Every phase length and the WAIT settings are taken from the configuration inputs at the moment a request is accepted. Changing them during an access therefore has no effect on that access. A one-cycle done pulse closes each access. For reads, the captured data is presented alongside it.

Top module: `mux_async_seq`

## Requirements
- R1: After acceptance, the address setup phase lasts max(cfg_addset,1) cycles. During it, mem_ce_n and mem_adv_n are low, and the latched address is on ad_out with ad_oe high.
- R2: The address hold phase lasts cfg_addhld cycles and is skipped when that value is 0. The address stays driven with ad_oe high and mem_adv_n high, and WAIT never lengthens either address phase.
- R3: With WAIT inactive, the data strobe window lasts max(cfg_datast,1) cycles. A read holds mem_oe_n low with ad_oe low. A write holds mem_we_n low and drives the write data with ad_oe high. mem_oe_n and mem_we_n are never low together.
- R4: When the latched enable is 1, WAIT is active if its value after two clock stages equals the latched polarity (1 = active high, 0 = active low). While WAIT is active on the last strobe cycle, the strobe window is repeated.
- R5: When the latched WAIT enable is 0, mem_wait has no effect on any output timing.
- R6: The data hold phase lasts cfg_datahld cycles for a read and cfg_datahld+1 cycles for a write. A length of 0 skips the phase. mem_ce_n stays low through it, and on writes the write data stays driven.
- R7: A read captures ad_in on the last cycle of the strobe window. done is high for exactly one cycle, namely the cycle after the last data-phase cycle. rd_data shows the captured value from that cycle on, and writes leave it unchanged.
- R8: req_ready is high only while idle, and a request is accepted on a cycle with req_valid and req_ready both high. After an access, mem_ce_n stays high for cfg_busturn turnaround cycles plus the idle accepting cycle. All configuration inputs are sampled only at acceptance.
- R9: While rst_n is low, mem_ce_n, mem_adv_n, mem_oe_n and mem_we_n are high, ad_oe and done are low, rd_data is 0 and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_W | Access address |
| req_wdata | input | BUS_W | Write data |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | BUS_W | Last captured read data |
| cfg_addset | input | CFG_W | Address setup length (0 treated as 1) |
| cfg_addhld | input | CFG_W | Address hold length |
| cfg_datast | input | CFG_W | Data strobe length (0 treated as 1) |
| cfg_datahld | input | CFG_W | Data hold base length |
| cfg_busturn | input | CFG_W | Turnaround gap length |
| cfg_wait_en | input | 1 | WAIT stretching enable |
| cfg_wait_pol | input | 1 | WAIT active level |
| mem_wait | input | 1 | Asynchronous WAIT from memory |
| ad_in | input | BUS_W | Shared bus input value |
| ad_out | output | BUS_W | Shared bus output value |
| ad_oe | output | 1 | Shared bus drive enable |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach from the ports is WAIT changing state exactly on the last strobe cycle, seen two stages late, under both polarities. WAIT toggling during the address phases is a second such case. The stimulus drives mem_wait from a free-running pseudo-random sequence that is not tied to the access. Across many accesses with small random phase lengths and random polarity, every alignment of a WAIT edge to a phase boundary occurs. Some accesses also change the configuration right after acceptance, which checks that the lengths were latched.

// File: rtl/masq_pkg.sv
package masq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASET = 3'd1,
    PH_AHLD = 3'd2,
    PH_DSET = 3'd3,
    PH_DHLD = 3'd4,
    PH_TURN = 3'd5
  } phase_e;

  // Programmed lengths of 0 are promoted to one cycle for phases that cannot vanish.
  function automatic int unsigned min_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Data hold is one cycle longer for writes than for reads.
  function automatic int unsigned hold_len(input int unsigned n, input logic wr);
    return wr ? n + 1 : n;
  endfunction

endpackage

// File: rtl/masq_wait_sync.sv
module masq_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_in,
  input  logic wait_en,
  input  logic wait_pol,
  output logic wait_act
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= wait_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], wait_in};
      end
    end
  endgenerate

  assign wait_act = wait_en && (sh[STAGES-1] == wait_pol);

endmodule

// File: rtl/masq_phase_ctrl.sv
module masq_phase_ctrl
  import masq_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CFG_W-1:0] cfg_addset,
  input  logic [CFG_W-1:0] cfg_addhld,
  input  logic [CFG_W-1:0] cfg_datast,
  input  logic [CFG_W-1:0] cfg_datahld,
  input  logic [CFG_W-1:0] cfg_busturn,
  input  logic             cfg_wait_en,
  input  logic             cfg_wait_pol,
  input  logic             wait_act,
  output phase_e           phase,
  output logic             wr_q,
  output logic             wen_q,
  output logic             wpol_q,
  output logic             accept,
  output logic             capture,
  output logic             done,
  output logic             ready
);
  localparam int CNT_W = CFG_W + 1;
  localparam int GAP_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  phase_e           ph, ph_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CFG_W-1:0] ah_q, ds_q, dh_q, bt_q;
  logic             fin;
  logic             last_cyc;
  logic [CNT_W-1:0] dh_len;

  assign phase    = ph;
  assign ready    = (ph == PH_IDLE);
  assign last_cyc = (cnt <= CNT_ONE);
  assign dh_len   = CNT_W'(hold_len(int'(dh_q), wr_q));

  always_comb begin
    ph_n    = ph;
    cnt_n   = cnt;
    fin     = 1'b0;
    capture = 1'b0;
    accept  = req_valid && (ph == PH_IDLE);
    unique case (ph)
      PH_IDLE: begin
        if (accept) begin
          ph_n  = PH_ASET;
          cnt_n = CNT_W'(min_one(int'(cfg_addset)));
        end
      end
      PH_ASET: begin
        if (!last_cyc) cnt_n = cnt - CNT_ONE;
        else if (ah_q != '0) begin
          ph_n  = PH_AHLD;
          cnt_n = {1'b0, ah_q};
        end else begin
          ph_n  = PH_DSET;
          cnt_n = CNT_W'(min_one(int'(ds_q)));
        end
      end
      PH_AHLD: begin
        if (!last_cyc) cnt_n = cnt - CNT_ONE;
        else begin
          ph_n  = PH_DSET;
          cnt_n = CNT_W'(min_one(int'(ds_q)));
        end
      end
      PH_DSET: begin
        if (!last_cyc) cnt_n = cnt - CNT_ONE;
        else if (!wait_act) begin
          capture = !wr_q;
          if (dh_len != '0) begin
            ph_n  = PH_DHLD;
            cnt_n = dh_len;
          end else begin
            fin = 1'b1;
          end
        end
      end
      PH_DHLD: begin
        if (!last_cyc) cnt_n = cnt - CNT_ONE;
        else           fin   = 1'b1;
      end
      PH_TURN: begin
        if (!last_cyc) cnt_n = cnt - CNT_ONE;
        else           ph_n  = PH_IDLE;
      end
      default: ph_n = PH_IDLE;
    endcase
    if (fin) begin
      if (bt_q != '0) begin
        ph_n  = PH_TURN;
        cnt_n = {1'b0, bt_q};
      end else begin
        ph_n  = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      done   <= 1'b0;
      ah_q   <= '0;
      ds_q   <= '0;
      dh_q   <= '0;
      bt_q   <= '0;
      wr_q   <= 1'b0;
      wen_q  <= 1'b0;
      wpol_q <= 1'b0;
    end else begin
      ph   <= ph_n;
      cnt  <= cnt_n;
      done <= fin;
      if (accept) begin
        ah_q   <= cfg_addhld;
        ds_q   <= cfg_datast;
        dh_q   <= cfg_datahld;
        bt_q   <= cfg_busturn;
        wr_q   <= req_write;
        wen_q  <= cfg_wait_en;
        wpol_q <= cfg_wait_pol;
      end
    end
  end

  // Observation of the chip-select-high gap for the turnaround property.
  logic [GAP_W-1:0] gap_cnt;
  logic [CFG_W-1:0] gap_need;
  logic             ce_high;
  assign ce_high = (ph == PH_IDLE) || (ph == PH_TURN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      gap_need <= '0;
    end else begin
      if (!ce_high)           gap_cnt <= '0;
      else if (~&gap_cnt)     gap_cnt <= gap_cnt + GAP_W'(1);
      if (fin)                gap_need <= bt_q;
    end
  end

  AST_ASET_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ASET && !last_cyc) |=> (ph == PH_ASET && cnt == $past(cnt) - CNT_ONE)); // R1
  AST_ADDR_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_ASET || ph == PH_AHLD) && last_cyc && wait_act) |=> (ph != $past(ph))); // R2
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DSET && last_cyc && wait_act) |=> (ph == PH_DSET)); // R4
  AST_WAIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DSET && last_cyc && !wen_q) |=> (ph != PH_DSET)); // R5
  AST_HOLD_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DHLD && last_cyc) |=> done); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (gap_cnt >= GAP_W'(gap_need))); // R8

endmodule

// File: rtl/masq_bus_drv.sv
module masq_bus_drv
  import masq_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic             wr_q,
  input  logic             accept,
  input  logic             capture,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  input  logic [BUS_W-1:0] ad_in,
  output logic             ce_n,
  output logic             adv_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic [BUS_W-1:0] rd_data
);
  logic [BUS_W-1:0] addr_q, wdata_q, rd_q;
  logic             addr_ph, data_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rd_q <= ad_in;
    end
  end

  always_comb begin
    addr_ph = (phase == PH_ASET) || (phase == PH_AHLD);
    data_ph = (phase == PH_DSET) || (phase == PH_DHLD);
    ce_n    = !(addr_ph || data_ph);
    adv_n   = (phase != PH_ASET);
    oe_n    = !(phase == PH_DSET && !wr_q);
    we_n    = !(phase == PH_DSET && wr_q);
    ad_oe   = addr_ph || (data_ph && wr_q);
    ad_out  = addr_ph ? addr_q : wdata_q;
  end

  assign rd_data = rd_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n)); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ad_oe); // R3
  AST_ADV_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> !ce_n); // R1
  AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rd_q)); // R7

endmodule

// File: rtl/mux_async_seq.sv
module mux_async_seq
  import masq_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int CFG_W     = 8,
  parameter int WAIT_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             done,
  output logic [BUS_W-1:0] rd_data,
  input  logic [CFG_W-1:0] cfg_addset,
  input  logic [CFG_W-1:0] cfg_addhld,
  input  logic [CFG_W-1:0] cfg_datast,
  input  logic [CFG_W-1:0] cfg_datahld,
  input  logic [CFG_W-1:0] cfg_busturn,
  input  logic             cfg_wait_en,
  input  logic             cfg_wait_pol,
  input  logic             mem_wait,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             mem_ce_n,
  output logic             mem_adv_n,
  output logic             mem_oe_n,
  output logic             mem_we_n
);
  phase_e phase;
  logic   wr_q, wen_q, wpol_q, accept, capture, wait_act;

  masq_wait_sync #(.STAGES(WAIT_SYNC)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_in  (mem_wait),
    .wait_en  (wen_q),
    .wait_pol (wpol_q),
    .wait_act (wait_act)
  );

  masq_phase_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .cfg_addset   (cfg_addset),
    .cfg_addhld   (cfg_addhld),
    .cfg_datast   (cfg_datast),
    .cfg_datahld  (cfg_datahld),
    .cfg_busturn  (cfg_busturn),
    .cfg_wait_en  (cfg_wait_en),
    .cfg_wait_pol (cfg_wait_pol),
    .wait_act     (wait_act),
    .phase        (phase),
    .wr_q         (wr_q),
    .wen_q        (wen_q),
    .wpol_q       (wpol_q),
    .accept       (accept),
    .capture      (capture),
    .done         (done),
    .ready        (req_ready)
  );

  masq_bus_drv #(.BUS_W(BUS_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .wr_q      (wr_q),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .ce_n      (mem_ce_n),
    .adv_n     (mem_adv_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .rd_data   (rd_data)
  );

  AST_READY_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n); // R8

endmodule

// File: tb/tb_mux_async_seq.sv
`timescale 1ns/1ps
module tb_mux_async_seq;
  localparam int W  = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [W-1:0]  req_addr = '0, req_wdata = '0, ad_in = 16'h1234;
  logic [CW-1:0] cfg_addset = '0, cfg_addhld = '0, cfg_datast = '0, cfg_datahld = '0, cfg_busturn = '0;
  logic          cfg_wait_en = 1'b0, cfg_wait_pol = 1'b0, mem_wait = 1'b0;
  logic          req_ready, done, ad_oe, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n;
  logic [W-1:0]  rd_data, ad_out;

  always #2.5 clk = ~clk;

  mux_async_seq #(.BUS_W(W), .CFG_W(CW), .WAIT_SYNC(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .cfg_addset(cfg_addset), .cfg_addhld(cfg_addhld),
    .cfg_datast(cfg_datast), .cfg_datahld(cfg_datahld), .cfg_busturn(cfg_busturn),
    .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol), .mem_wait(mem_wait),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .mem_ce_n(mem_ce_n),
    .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  int checks = 0, errors = 0, cyc = 0;
  string ctx = "R3";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model: 0 idle, 1 addr setup, 2 addr hold, 3 strobe, 4 data hold, 5 gap
  int m_ph = 0, m_left = 0, hl = 0;
  bit m_done = 0, m_wr = 0, m_wen = 0, m_wpol = 0, s0 = 0, s1 = 0, m_fin = 0;
  int m_ah = 0, m_ds = 0, m_dh = 0, m_bt = 0;
  logic [W-1:0] m_addr = '0, m_wdata = '0, m_rd = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_done = 0; m_rd = '0; s0 = 0; s1 = 0;
      m_wr = 0; m_wen = 0; m_wpol = 0;
    end else begin
      m_done = 0; m_fin = 0;
      if (m_ph == 0) begin
        if (req_valid) begin
          m_ah = cfg_addhld; m_ds = cfg_datast; m_dh = cfg_datahld; m_bt = cfg_busturn;
          m_wr = req_write; m_wen = cfg_wait_en; m_wpol = cfg_wait_pol;
          m_addr = req_addr; m_wdata = req_wdata;
          m_ph = 1; m_left = (cfg_addset == 0) ? 1 : int'(cfg_addset);
        end
      end else if (m_left > 1) begin
        m_left--;
      end else if (m_ph == 1) begin
        if (m_ah > 0) begin m_ph = 2; m_left = m_ah; end
        else begin m_ph = 3; m_left = (m_ds == 0) ? 1 : m_ds; end
      end else if (m_ph == 2) begin
        m_ph = 3; m_left = (m_ds == 0) ? 1 : m_ds;
      end else if (m_ph == 3) begin
        if (!(m_wen && (s1 == m_wpol))) begin
          if (!m_wr) m_rd = ad_in;
          hl = m_wr ? m_dh + 1 : m_dh;
          if (hl > 0) begin m_ph = 4; m_left = hl; end
          else m_fin = 1;
        end
      end else if (m_ph == 4) begin
        m_fin = 1;
      end else begin
        m_ph = 0;
      end
      if (m_fin) begin
        m_done = 1;
        if (m_bt > 0) begin m_ph = 5; m_left = m_bt; end
        else m_ph = 0;
      end
      s1 = s0; s0 = mem_wait;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    bit eoe;
    eoe = (m_ph == 1) || (m_ph == 2) || (m_wr && (m_ph == 3 || m_ph == 4));
    chk(req_ready == (m_ph == 0), "R8", "req_ready", int'(req_ready), int'(m_ph == 0));
    chk(mem_ce_n == !(m_ph >= 1 && m_ph <= 4), "R8", "mem_ce_n", int'(mem_ce_n), int'(!(m_ph >= 1 && m_ph <= 4)));
    chk(mem_adv_n == (m_ph != 1), "R1", "mem_adv_n", int'(mem_adv_n), int'(m_ph != 1));
    chk(mem_oe_n == !(m_ph == 3 && !m_wr), ctx, "mem_oe_n", int'(mem_oe_n), int'(!(m_ph == 3 && !m_wr)));
    chk(mem_we_n == !(m_ph == 3 && m_wr), ctx, "mem_we_n", int'(mem_we_n), int'(!(m_ph == 3 && m_wr)));
    chk(ad_oe == eoe, "R2", "ad_oe", int'(ad_oe), int'(eoe));
    if (eoe)
      chk(ad_out == ((m_ph <= 2) ? m_addr : m_wdata), "R2", "ad_out", int'(ad_out),
          int'((m_ph <= 2) ? m_addr : m_wdata));
    chk(done == m_done, "R6", "done", int'(done), int'(m_done));
    chk(rd_data == m_rd, "R7", "rd_data", int'(rd_data), int'(m_rd));
  end

  // Bus and WAIT stimulus: wmode 0 = low, 1 = pseudo-random, 2 = high
  int wmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    ad_in <= ad_in + 16'h3b1d;
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (wmode)
      0: mem_wait <= 1'b0;
      1: mem_wait <= lfsr[2] & lfsr[7];
      default: mem_wait <= 1'b1;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int strobe_cycles = 0;

  task automatic run(input bit wr, input logic [W-1:0] a, input logic [W-1:0] d,
                     input int as, input int ah, input int ds, input int dh, input int bt,
                     input bit wen, input bit wpol, input int wm, input bit scramble);
    int t;
    wmode = wm;
    cfg_addset = CW'(as); cfg_addhld = CW'(ah); cfg_datast = CW'(ds);
    cfg_datahld = CW'(dh); cfg_busturn = CW'(bt);
    cfg_wait_en = wen; cfg_wait_pol = wpol;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin  // R8: configuration after acceptance must not matter
      cfg_addhld = 8'd7; cfg_datast = 8'd9; cfg_datahld = 8'd6; cfg_busturn = 8'd5;
      cfg_wait_en = ~wen; cfg_wait_pol = ~wpol;
    end
    t = 0; strobe_cycles = 0;
    while (!done && t < 3000) begin
      if (!mem_oe_n || !mem_we_n) strobe_cycles++;
      @(negedge clk);
      t++;
    end
    if (t >= 3000) chk(1'b0, "R7", "done timeout", t, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n, "R9", "strobes in reset",
        int'({mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n}), 15);
    chk(!ad_oe && !done && req_ready, "R9", "oe/done/ready in reset", int'({ad_oe, done, req_ready}), 1);
    chk(rd_data == '0, "R9", "rd_data in reset", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R6: minimum lengths, zero setup values promoted to one
    run(0, 16'h1111, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run(1, 16'h2222, 16'hBEEF, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    // R2 R6 R8: longer phases and a turnaround gap
    run(0, 16'h3333, 16'h0, 3, 2, 4, 3, 3, 0, 0, 0, 0);
    run(1, 16'h4444, 16'hCAFE, 2, 3, 2, 2, 4, 0, 0, 0, 1);
    run(0, 16'h4545, 16'h0, 1, 1, 1, 1, 1, 0, 0, 0, 1);
    // R5: WAIT held active-looking but disabled
    run(0, 16'h5555, 16'h0, 1, 1, 3, 1, 0, 0, 1, 2, 0);
    chk(strobe_cycles == 3, "R5", "strobe length with WAIT disabled", strobe_cycles, 3);
    run(1, 16'h5656, 16'h7777, 2, 0, 2, 0, 1, 0, 0, 2, 0);
    chk(strobe_cycles == 2, "R5", "write strobe with WAIT disabled", strobe_cycles, 2);
    // R4: active-high and active-low WAIT with random timing
    ctx = "R4";
    for (int i = 0; i < 20; i++)
      run(i[0], 16'h6000 + 16'(i), 16'h9000 + 16'(i), 1 + i % 3, i % 2, 1 + i % 5, i % 3, i % 2,
          1, i[1], 1, 0);
    // R4: WAIT inactive level held, strobe length unaffected
    run(0, 16'h6a6a, 16'h0, 1, 0, 4, 0, 0, 1, 1, 0, 0);
    chk(strobe_cycles == 4, "R4", "strobe length with WAIT inactive", strobe_cycles, 4);
    // R7 R8: random mix, back to back, with scrambled configuration
    for (int i = 0; i < 80; i++)
      run(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
          $urandom_range(0, 4), $urandom_range(0, 3), $urandom_range(0, 6),
          $urandom_range(0, 3), $urandom_range(0, 4),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1, 1'($urandom_range(0, 1)));
    ctx = "R3";
    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule